// File: doc/BRIEF.md
# Indexed Palette Lookup with Host Register Port

The block turns an 8-bit pixel index into a 24-bit RGB colour, using a 256-entry table that a host fills through a narrow register port. The host first writes a table index to an address register. It then writes the three colour components, red first, then green, then blue, to a colour-data port. Once the blue byte lands, the whole entry is written in one step and the index moves on to the next entry. This lets a host fill a run of consecutive entries with a single address write. Reads of the colour-data port walk the table in the same component order.

The same address register also selects among four control registers, reached through a separate control port. These are a read mask, a blink mask, a command register and a test register. The read mask is ANDed with every pixel index before the lookup. All host data travels in the top byte of a 32-bit word. The lookup runs every clock and delivers its result one cycle after the pixel index is presented.

Top module: `pal_dac_port`

## Requirements
- R1: After synchronous reset, the registers hold the following values: index 0, component position red, rdata 0 and rgb_out 0. The control registers at addresses 4, 5, 6 and 7 hold 0xFF, 0x00, 0x73 and 0x00.
- R2: A write with sel=0 (address register) loads the index from wdata[31:24] and returns the component position to red. A read with sel=0 returns the current index in rdata[31:24].
- R3: With sel=1 (colour data), the first, second and third writes after an address write supply red, green and blue from wdata[31:24]. The table entry changes only on the blue write. A sequence that an address write cuts short leaves the entry unchanged.
- R4: After a blue write, the index advances by one and wraps from 255 to 0. The next three colour writes then fill that following entry.
- R5: A write with sel=2 (control) loads wdata[31:24] into the control register that the index selects, at index 4 to 7. At any other index the write is ignored. A control read returns the selected register, or 0 at any other index. Control accesses leave the index and component position unchanged.
- R6: rgb_out = {red, green, blue} of the entry at (pixel_in AND read mask). It appears on the clock edge after pixel_in is presented, with red in bits 23:16 and blue in bits 7:0.
- R7: Each read with sel=1 returns one component of the entry at the index, in the order red, green, blue, in rdata[31:24]. rdata is valid from the clock edge after rd_en. The index advances after the blue read.
- R8: Suppose a blue write commits an entry in the same cycle as the lookup of that entry. Then rgb_out shows the old contents for that cycle and the new contents from the following cycle.
- R9: A write with sel=3 changes no state. A read is carried out only when wr_en is low. rdata holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| sel | input | 2 | Port select: 0 address, 1 colour data, 2 control, 3 none |
| wdata | input | 32 | Host write data, payload in bits 31:24 |
| rdata | output | 32 | Host read data, payload in bits 31:24 |
| pixel_in | input | 8 | Pixel index to look up |
| rgb_out | output | 24 | Registered RGB colour |

## Verification
A host blue write can commit a table entry in the same cycle that the pixel lookup reads that entry. The bench provokes this by writing red and green to an entry that already holds a known colour. It then drives the blue write and that entry's pixel index on the same edge. rgb_out is checked for the old colour on the first sampled cycle and the new colour on the next. The bench also cuts a colour sequence short with an address write, then checks both that the entry is unchanged and that the next sequence starts again at red.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int HOST_W    = 32;
    localparam int COMP_W    = 8;
    localparam int IDX_W     = 8;
    localparam int DEPTH     = 1 << IDX_W;
    localparam int RGB_W     = 3 * COMP_W;
    localparam int N_CTRL    = 4;
    localparam int CTRL_BASE = 4;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_COLOR = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        COMP_R = 2'd0,
        COMP_G = 2'd1,
        COMP_B = 2'd2
    } comp_e;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    function automatic comp_e comp_next(input comp_e c);
        case (c)
            COMP_R:  return COMP_G;
            COMP_G:  return COMP_B;
            default: return COMP_R;
        endcase
    endfunction

    function automatic logic [COMP_W-1:0] ctrl_init(input int n);
        case (n)
            0:       return 8'hFF;
            2:       return 8'h73;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [COMP_W-1:0] comp_pick(input rgb_t c, input comp_e p);
        case (p)
            COMP_R:  return c.r;
            COMP_G:  return c.g;
            default: return c.b;
        endcase
    endfunction
endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_we,
    input  logic              color_we,
    input  logic              color_re,
    input  logic [COMP_W-1:0] wtop,
    output logic [IDX_W-1:0]  idx,
    output comp_e             comp,
    output logic              commit,
    output rgb_t              commit_rgb
);
    logic [COMP_W-1:0] stage_r;
    logic [COMP_W-1:0] stage_g;

    assign commit     = color_we && (comp == COMP_B);
    assign commit_rgb = '{r: stage_r, g: stage_g, b: wtop};

    always_ff @(posedge clk) begin
        if (rst) begin
            idx     <= '0;
            comp    <= COMP_R;
            stage_r <= '0;
            stage_g <= '0;
        end else if (addr_we) begin
            idx  <= wtop;
            comp <= COMP_R;
        end else if (color_we || color_re) begin
            if (color_we && comp == COMP_R) stage_r <= wtop;
            if (color_we && comp == COMP_G) stage_g <= wtop;
            if (comp == COMP_B) idx <= idx + 1'b1;
            comp <= comp_next(comp);
        end
    end

    // R2
    addr_to_red_chk: assert property (@(posedge clk) disable iff (rst)
        addr_we |=> (comp == COMP_R) && (idx == $past(wtop)));

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> idx == $past(idx) + 1'b1);
endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [COMP_W-1:0] wtop,
    output logic [COMP_W-1:0] rmask,
    output logic [COMP_W-1:0] rd_val
);
    logic [COMP_W-1:0] regs [N_CTRL];
    logic [N_CTRL*COMP_W-1:0] regs_flat;

    for (genvar n = 0; n < N_CTRL; n++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[n] <= ctrl_init(n);
            else if (we && idx == IDX_W'(CTRL_BASE + n))
                regs[n] <= wtop;
        end
        assign regs_flat[n*COMP_W +: COMP_W] = regs[n];
    end

    always_comb begin
        rd_val = '0;
        for (int n = 0; n < N_CTRL; n++)
            if (idx == IDX_W'(CTRL_BASE + n)) rd_val = regs[n];
    end

    assign rmask = regs[0];

    // R5
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs_flat));
endmodule

// File: rtl/pal_lut.sv
module pal_lut
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [IDX_W-1:0]  wr_idx,
    input  rgb_t              wr_rgb,
    input  logic [IDX_W-1:0]  pix,
    input  logic [COMP_W-1:0] rmask,
    input  logic [IDX_W-1:0]  rd_idx,
    output rgb_t              rd_rgb,
    output rgb_t              rgb_out
);
    rgb_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (commit) mem[wr_idx] <= wr_rgb;
    end

    always_ff @(posedge clk) begin
        if (rst) rgb_out <= '0;
        else     rgb_out <= mem[pix & rmask];
    end

    assign rd_rgb = mem[rd_idx];
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        sel,
    input  logic [HOST_W-1:0] wdata,
    output logic [HOST_W-1:0] rdata,
    input  logic [IDX_W-1:0]  pixel_in,
    output logic [RGB_W-1:0]  rgb_out
);
    localparam int PAD_W = HOST_W - COMP_W;

    sel_e              sel_s;
    logic [COMP_W-1:0] wtop;
    logic              addr_we, color_we, ctrl_we, rd_go, color_re;
    logic [IDX_W-1:0]  idx;
    comp_e             comp;
    logic              commit;
    rgb_t              commit_rgb, rd_rgb, lut_out;
    logic [COMP_W-1:0] rmask, ctrl_rd, rd_byte;

    assign sel_s    = sel_e'(sel);
    assign wtop     = wdata[HOST_W-1 -: COMP_W];
    assign addr_we  = wr_en && sel_s == SEL_ADDR;
    assign color_we = wr_en && sel_s == SEL_COLOR;
    assign ctrl_we  = wr_en && sel_s == SEL_CTRL;
    assign rd_go    = rd_en && !wr_en;
    assign color_re = rd_go && sel_s == SEL_COLOR;

    pal_seq u_seq (
        .clk(clk), .rst(rst), .addr_we(addr_we), .color_we(color_we),
        .color_re(color_re), .wtop(wtop), .idx(idx), .comp(comp),
        .commit(commit), .commit_rgb(commit_rgb)
    );

    pal_ctrl u_ctrl (
        .clk(clk), .rst(rst), .we(ctrl_we), .idx(idx), .wtop(wtop),
        .rmask(rmask), .rd_val(ctrl_rd)
    );

    pal_lut u_lut (
        .clk(clk), .rst(rst), .commit(commit), .wr_idx(idx),
        .wr_rgb(commit_rgb), .pix(pixel_in), .rmask(rmask),
        .rd_idx(idx), .rd_rgb(rd_rgb), .rgb_out(lut_out)
    );

    always_comb begin
        case (sel_s)
            SEL_ADDR:  rd_byte = idx;
            SEL_COLOR: rd_byte = comp_pick(rd_rgb, comp);
            SEL_CTRL:  rd_byte = ctrl_rd;
            default:   rd_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_go) rdata <= {rd_byte, PAD_W'(0)};
    end

    assign rgb_out = lut_out;

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(rdata));
endmodule

// File: tb/pal_dac_port_tb.sv
module pal_dac_port_tb;
    import pal_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pixel_in = '0;
    logic [23:0] rgb_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pal_dac_port u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
        .wdata(wdata), .rdata(rdata), .pixel_in(pixel_in), .rgb_out(rgb_out)
    );

    // {index, red, green, blue}
    localparam logic [31:0] VEC [5] = '{
        32'h03_11_22_33,
        32'h0A_A1_B2_C3,
        32'h14_40_50_60,
        32'h80_77_88_99,
        32'hFF_FE_ED_01
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] s, input logic [7:0] b);
        wr_en = 1'b1; sel = s; wdata = {b, 24'h0};
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic host_rd(input logic [1:0] s, output logic [31:0] v);
        rd_en = 1'b1; sel = s;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic look(input logic [7:0] p, output logic [23:0] v);
        pixel_in = p;
        @(negedge clk);
        v = rgb_out;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic [23:0] pv;

        repeat (3) @(negedge clk);
        check("R1 rgb_out in reset", {8'h0, rgb_out}, 32'h0);
        check("R1 rdata in reset", rdata, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        host_rd(SEL_ADDR, rv);
        check("R1 index after reset", rv, 32'h0);
        for (int i = 0; i < 4; i++) begin
            host_wr(SEL_ADDR, 8'(4 + i));
            host_rd(SEL_CTRL, rv);
            check("R1 control reset value", rv, {(i == 0) ? 8'hFF : (i == 2) ? 8'h73 : 8'h00, 24'h0});
        end

        for (int v = 0; v < 5; v++) begin
            host_wr(SEL_ADDR, VEC[v][31:24]);
            host_wr(SEL_COLOR, VEC[v][23:16]);
            host_wr(SEL_COLOR, VEC[v][15:8]);
            host_wr(SEL_COLOR, VEC[v][7:0]);
            look(VEC[v][31:24], pv);
            check("R3 entry after rgb writes", {8'h0, pv}, {8'h0, VEC[v][23:0]});
        end

        // R4: index wrapped from 255 to 0
        host_wr(SEL_COLOR, 8'h12);
        host_wr(SEL_COLOR, 8'h34);
        host_wr(SEL_COLOR, 8'h56);
        look(8'h00, pv);
        check("R4 wrap to entry 0", {8'h0, pv}, 32'h00123456);
        host_rd(SEL_ADDR, rv);
        check("R4 index after entry 0", rv, 32'h01000000);

        // R3 partial sequence, R2 counter reset
        host_wr(SEL_ADDR, 8'h0A);
        host_wr(SEL_COLOR, 8'hDE);
        host_wr(SEL_COLOR, 8'hAD);
        look(8'h0A, pv);
        check("R3 partial write not visible", {8'h0, pv}, 32'h00A1B2C3);
        host_wr(SEL_ADDR, 8'h0A);
        host_wr(SEL_COLOR, 8'h0A);
        host_wr(SEL_COLOR, 8'h0B);
        host_wr(SEL_COLOR, 8'h0C);
        look(8'h0A, pv);
        check("R2 restart at red", {8'h0, pv}, 32'h000A0B0C);

        // R7 colour reads
        host_wr(SEL_ADDR, 8'h0A);
        host_rd(SEL_COLOR, rv);
        check("R7 read red", rv, 32'h0A000000);
        host_rd(SEL_COLOR, rv);
        check("R7 read green", rv, 32'h0B000000);
        host_rd(SEL_COLOR, rv);
        check("R7 read blue", rv, 32'h0C000000);
        host_rd(SEL_ADDR, rv);
        check("R7 index after reads", rv, 32'h0B000000);

        // R6 read mask
        host_wr(SEL_ADDR, 8'h04);
        host_wr(SEL_CTRL, 8'h0F);
        look(8'hFA, pv);
        check("R6 masked lookup FA", {8'h0, pv}, 32'h000A0B0C);
        look(8'hF3, pv);
        check("R6 masked lookup F3", {8'h0, pv}, 32'h00112233);
        host_wr(SEL_CTRL, 8'hFF);
        look(8'h80, pv);
        check("R6 full mask lookup", {8'h0, pv}, 32'h00778899);

        // R5 ignored control write
        host_wr(SEL_ADDR, 8'h08);
        host_wr(SEL_CTRL, 8'h55);
        host_rd(SEL_CTRL, rv);
        check("R5 control outside 4..7", rv, 32'h0);
        host_rd(SEL_ADDR, rv);
        check("R5 index kept by control", rv, 32'h08000000);
        host_wr(SEL_ADDR, 8'h06);
        host_rd(SEL_CTRL, rv);
        check("R5 command unchanged", rv, 32'h73000000);

        // R8 same-cycle commit and lookup
        host_wr(SEL_ADDR, 8'h14);
        host_wr(SEL_COLOR, 8'h01);
        host_wr(SEL_COLOR, 8'h02);
        wr_en = 1'b1; sel = SEL_COLOR; wdata = 32'h03000000; pixel_in = 8'h14;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        check("R8 old value same cycle", {8'h0, rgb_out}, 32'h00405060);
        @(negedge clk);
        check("R8 new value next cycle", {8'h0, rgb_out}, 32'h00010203);

        // R9 sel=3 write, read during write
        host_wr(SEL_NONE, 8'h99);
        host_rd(SEL_ADDR, rv);
        check("R9 sel3 write ignored", rv, 32'h15000000);
        look(8'h14, pv);
        check("R9 entry untouched", {8'h0, pv}, 32'h00010203);
        wr_en = 1'b1; rd_en = 1'b1; sel = SEL_NONE; wdata = '0;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R9 read blocked by write", rdata, 32'h15000000);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule